// File: doc/BRIEF.md
# Upper-Memory Shadow Routing Decoder

This block routes every memory cycle that falls between 640K and 1M either to on-board DRAM or out to the ISA bus. The 16K windows at C0000, C4000, C8000 and CC000 and the 64K segments at D0000, E0000 and F0000 each carry a read enable and a separate write enable. A set enable lets the matching access be claimed by DRAM. A clear enable sends the access to the ISA bus, and the DRAM bank decode is not consulted. Any address in the window that no enable covers also goes to the ISA bus.

The D, E and F segments have two sets of enables, one for normal operation and one for system-management mode. The SMM-active input picks the set for each cycle. This lets memory that only SMM code can see sit at those addresses. All enables are written through a small indexed write port, and all of them clear on reset. After power-up, the ROM and adapter areas are therefore served from the ISA bus.

The routing decision is combinational from the cycle inputs and the stored enables. A configuration write takes effect at the next clock edge.

Top module: `shadow_route`

## Requirements
- R1: After reset every enable is 0, so every in-window cycle asserts isa_fwd and leaves dram_claim low.
- R2: Address bits [19:16] = C select one of the four 16K windows by bits [15:14]: 0, 1, 2 and 3 use enable slots 0, 1, 2 and 3. Segments D, E and F use normal slots 4, 5 and 6.
- R3: A read (mem_write=0) is judged only by the slot's read enable, which is cfg_wdata bit 0. A write is judged only by the slot's write enable, which is cfg_wdata bit 1.
- R4: When the applicable enable is 1, dram_claim=1 and isa_fwd=0. When it is 0, dram_claim=0 and isa_fwd=1.
- R5: While smm_active=1, segments D, E and F use slots 7, 8 and 9 instead of 4, 5 and 6. The C windows ignore smm_active.
- R6: For addresses F0000–FFFFF the F-segment enables decide, even though the E range nominally extends to FFFFF.
- R7: Addresses A0000–BFFFF are inside the window but covered by no enable, and always assert isa_fwd.
- R8: Addresses below A0000, or with any bit at or above bit 20 set, drive both outputs low.
- R9: With mem_cyc=0 both outputs are low.
- R10: For any in-window cycle exactly one of dram_claim and isa_fwd is high.
- R11: A write with cfg_we=1 stores cfg_wdata into slot cfg_idx at the clock edge. Indices 10 to 15 change no slot.
- R12: A configuration write in the same cycle as a memory cycle to the same slot does not affect that cycle's routing. The new value applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mem_cyc | input | 1 | A memory cycle is present this clock |
| mem_addr | input | ADDR_W (24) | Memory byte address |
| mem_write | input | 1 | 1 = write cycle, 0 = read cycle |
| smm_active | input | 1 | System-management mode is active |
| cfg_we | input | 1 | Enable slot write strobe |
| cfg_idx | input | 4 | Slot index, 0 to 9 valid |
| cfg_wdata | input | 2 | Bit 0 read enable, bit 1 write enable |
| dram_claim | output | 1 | The cycle is claimed by DRAM |
| isa_fwd | output | 1 | The cycle is forwarded to the ISA bus |

## Verification
A configuration update and a routing decision can land in the same clock, including the case where both touch the same slot. The bench provokes this by holding a write cycle to C0000 while it rewrites slot 0 from "read only" to "read and write". The output is judged twice. Before the edge it must still forward to ISA, because the old enable applies. After the edge, with the cycle inputs unchanged, it must claim DRAM.

// File: rtl/shadow_route_pkg.sv
package shadow_route_pkg;
  localparam int NUM_C_WIN   = 4;
  localparam int NUM_SEG64   = 3;
  localparam int NUM_NORMAL  = NUM_C_WIN + NUM_SEG64;
  localparam int NUM_SLOTS   = NUM_NORMAL + NUM_SEG64;
  localparam int SLOT_W      = 4;
  localparam logic [3:0] SEG_FIRST_IN = 4'hA;
  localparam logic [3:0] SEG_C        = 4'hC;
  localparam logic [3:0] SEG_D        = 4'hD;

  typedef struct packed {
    logic wr_en;
    logic rd_en;
  } shadow_en_t;
endpackage

// File: rtl/shadow_addr_decode.sv
module shadow_addr_decode
  import shadow_route_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_scope,
  output logic              hit,
  output logic              smm_capable,
  output logic [SLOT_W-1:0] base_slot
);
  localparam int HI_W = ADDR_W - 20;

  logic [3:0] seg;
  logic       upper_zero;

  assign seg = addr[19:16];

  generate
    if (HI_W > 0) begin : g_hi
      assign upper_zero = (addr[ADDR_W-1:20] == '0);
    end else begin : g_nohi
      assign upper_zero = 1'b1;
    end
  endgenerate

  always_comb begin
    in_scope    = upper_zero && (seg >= SEG_FIRST_IN);
    hit         = 1'b0;
    smm_capable = 1'b0;
    base_slot   = '0;
    if (in_scope) begin
      if (seg == SEG_C) begin
        hit       = 1'b1;
        base_slot = SLOT_W'(addr[15:14]);
      end else if (seg >= SEG_D) begin
        // each 64K segment owns its own slot; F wins over the wide E range
        hit         = 1'b1;
        smm_capable = 1'b1;
        base_slot   = SLOT_W'(NUM_C_WIN) + SLOT_W'(seg - SEG_D);
      end
    end
  end
endmodule

// File: rtl/shadow_cfg_regs.sv
module shadow_cfg_regs
  import shadow_route_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [SLOT_W-1:0]           idx,
  input  shadow_en_t                  wdata,
  output shadow_en_t [NUM_SLOTS-1:0]  slots
);
  shadow_en_t [NUM_SLOTS-1:0] slots_q;
  shadow_en_t [NUM_SLOTS-1:0] slots_d;
  logic       [NUM_SLOTS-1:0] slot_en;

  genvar g;
  generate
    for (g = 0; g < NUM_SLOTS; g++) begin : g_slot
      assign slot_en[g] = we && (idx == SLOT_W'(g));
      always_comb begin
        slots_d[g] = slots_q[g];
        if (slot_en[g]) slots_d[g] = wdata;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slots_q[g] <= '0;
        else if (slot_en[g]) slots_q[g] <= slots_d[g];
      end
    end
  endgenerate

  assign slots = slots_q;

  assert_cfg_store_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (idx < SLOT_W'(NUM_SLOTS))) |=> (slots[$past(idx)] == $past(wdata)));

  assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!we || (idx >= SLOT_W'(NUM_SLOTS))) |=> $stable(slots));
endmodule

// File: rtl/shadow_route_select.sv
module shadow_route_select
  import shadow_route_pkg::*;
(
  input  shadow_en_t [NUM_SLOTS-1:0] slots,
  input  logic                       cyc,
  input  logic                       in_scope,
  input  logic                       hit,
  input  logic                       smm_capable,
  input  logic                       smm,
  input  logic                       is_write,
  input  logic [SLOT_W-1:0]          base_slot,
  output logic                       claim,
  output logic                       fwd
);
  logic [SLOT_W-1:0] slot;
  shadow_en_t        en;
  logic              en_bit;

  always_comb begin
    slot = base_slot;
    if (smm_capable && smm) slot = base_slot + SLOT_W'(NUM_SEG64);
    en     = (slot < SLOT_W'(NUM_SLOTS)) ? slots[slot] : '0;
    en_bit = is_write ? en.wr_en : en.rd_en;
    claim  = cyc && in_scope && hit && en_bit;
    fwd    = cyc && in_scope && !claim;
  end
endmodule

// File: rtl/shadow_route.sv
module shadow_route
  import shadow_route_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_cyc,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_write,
  input  logic              smm_active,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_idx,
  input  logic [1:0]        cfg_wdata,
  output logic              dram_claim,
  output logic              isa_fwd
);
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic                       in_scope;
  logic                       hit;
  logic                       smm_capable;
  logic [SLOT_W-1:0]          base_slot;
  shadow_en_t [NUM_SLOTS-1:0] slots;
  shadow_en_t                 wd;

  assign wd = shadow_en_t'(cfg_wdata);

  shadow_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr        (mem_addr),
    .in_scope    (in_scope),
    .hit         (hit),
    .smm_capable (smm_capable),
    .base_slot   (base_slot)
  );

  shadow_cfg_regs u_cfg (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .we    (cfg_we),
    .idx   (cfg_idx),
    .wdata (wd),
    .slots (slots)
  );

  shadow_route_select u_sel (
    .slots       (slots),
    .cyc         (mem_cyc),
    .in_scope    (in_scope),
    .hit         (hit),
    .smm_capable (smm_capable),
    .smm         (smm_active),
    .is_write    (mem_write),
    .base_slot   (base_slot),
    .claim       (dram_claim),
    .fwd         (isa_fwd)
  );

  assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_cyc && in_scope) |-> (dram_claim != isa_fwd));

  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !mem_cyc |-> (!dram_claim && !isa_fwd));

  assert_oos_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_scope |-> (!dram_claim && !isa_fwd));

  assert_hole_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_cyc && in_scope && (mem_addr[19:17] == 3'b101)) |-> isa_fwd);
endmodule

// File: tb/shadow_route_tb_top.sv
module shadow_route_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mem_cyc, mem_write, smm_active, cfg_we;
  logic [23:0] mem_addr;
  logic [3:0]  cfg_idx;
  logic [1:0]  cfg_wdata;
  logic        dram_claim, isa_fwd;

  int n_run  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  shadow_route #(.ADDR_W(24)) dut_i (
    .clk(clk), .rst_n(rst_n), .mem_cyc(mem_cyc), .mem_addr(mem_addr),
    .mem_write(mem_write), .smm_active(smm_active), .cfg_we(cfg_we),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .dram_claim(dram_claim), .isa_fwd(isa_fwd)
  );

  // {addr[27:4], write[3], smm[2], exp_dram[1], exp_isa[0]}
  localparam int NV = 19;
  localparam logic [27:0] VEC [NV] = '{
    {24'h0C0000, 1'b0, 1'b0, 1'b1, 1'b0},  // R3 R4 read of slot0
    {24'h0C0000, 1'b1, 1'b0, 1'b0, 1'b1},  // R3 write of slot0
    {24'h0C4000, 1'b0, 1'b0, 1'b0, 1'b1},  // R2 slot1 read
    {24'h0C7FFF, 1'b1, 1'b0, 1'b1, 1'b0},  // R2 slot1 top
    {24'h0C8000, 1'b0, 1'b0, 1'b1, 1'b0},  // R2 slot2
    {24'h0CFFFF, 1'b1, 1'b0, 1'b0, 1'b1},  // R2 slot3
    {24'h0C0000, 1'b0, 1'b1, 1'b1, 1'b0},  // R5 C ignores smm
    {24'h0D0000, 1'b0, 1'b0, 1'b1, 1'b0},  // R5 D normal
    {24'h0D0000, 1'b0, 1'b1, 1'b0, 1'b1},  // R5 D smm read
    {24'h0DFFFF, 1'b1, 1'b1, 1'b1, 1'b0},  // R5 D smm write
    {24'h0E0000, 1'b1, 1'b0, 1'b1, 1'b0},  // R2 E normal
    {24'h0EFFFF, 1'b0, 1'b1, 1'b0, 1'b1},  // R5 E smm
    {24'h0F0000, 1'b0, 1'b0, 1'b0, 1'b1},  // R6 F beats E
    {24'h0FFFFF, 1'b1, 1'b1, 1'b1, 1'b0},  // R6 F smm
    {24'h0A0000, 1'b0, 1'b0, 1'b0, 1'b1},  // R7 hole
    {24'h0BFFFF, 1'b1, 1'b1, 1'b0, 1'b1},  // R7 hole top
    {24'h09FFFF, 1'b0, 1'b0, 1'b0, 1'b0},  // R8 below
    {24'h100000, 1'b0, 1'b0, 1'b0, 1'b0},  // R8 above
    {24'h1F0000, 1'b0, 1'b0, 1'b0, 1'b0}   // R8 alias
  };

  task automatic chk(input string req, input logic [1:0] exp);
    n_run++;
    if ({dram_claim, isa_fwd} !== exp) begin
      n_fail++;
      $display("FAIL %s addr=%h act dram/isa=%b exp=%b", req, mem_addr,
               {dram_claim, isa_fwd}, exp);
    end
  endtask

  task automatic cyc(input logic [23:0] a, input logic w, input logic s);
    @(negedge clk);
    mem_cyc = 1'b1; mem_addr = a; mem_write = w; smm_active = s;
    #1;
  endtask

  task automatic wr_cfg(input logic [3:0] i, input logic [1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = i; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    #150000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mem_cyc = 1'b0; mem_addr = '0; mem_write = 1'b0;
    smm_active = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    cyc(24'h0C0000, 1'b0, 1'b0); chk("R1", 2'b01);
    cyc(24'h0F0000, 1'b1, 1'b1); chk("R1", 2'b01);
    cyc(24'h0D8000, 1'b0, 1'b0); chk("R1", 2'b01);

    // R9 idle
    @(negedge clk); mem_cyc = 1'b0; mem_addr = 24'h0C0000; #1;
    chk("R9", 2'b00);

    wr_cfg(4'd0, 2'b01); wr_cfg(4'd1, 2'b10); wr_cfg(4'd2, 2'b11);
    wr_cfg(4'd3, 2'b00); wr_cfg(4'd4, 2'b01); wr_cfg(4'd5, 2'b11);
    wr_cfg(4'd6, 2'b00); wr_cfg(4'd7, 2'b10); wr_cfg(4'd8, 2'b00);
    wr_cfg(4'd9, 2'b11);

    for (int k = 0; k < NV; k++) begin
      cyc(VEC[k][27:4], VEC[k][3], VEC[k][2]);
      chk("R2-table", VEC[k][1:0]);
    end

    // R11 out-of-range indices change nothing
    wr_cfg(4'd10, 2'b00);
    wr_cfg(4'd14, 2'b00);
    wr_cfg(4'd15, 2'b11);
    cyc(24'h0C8000, 1'b0, 1'b0); chk("R11 slot2 kept", 2'b10);
    cyc(24'h0DC000, 1'b0, 1'b1); chk("R11 slot7 kept", 2'b01);
    cyc(24'h0FC000, 1'b1, 1'b0); chk("R11 slot6 kept", 2'b01);

    // R12 same-cycle config write and memory cycle
    @(negedge clk);
    mem_cyc = 1'b1; mem_addr = 24'h0C0000; mem_write = 1'b1; smm_active = 1'b0;
    cfg_we = 1'b1; cfg_idx = 4'd0; cfg_wdata = 2'b11;
    #1; chk("R12 old value", 2'b01);
    @(negedge clk); cfg_we = 1'b0; #1;
    chk("R12 new value", 2'b10);

    // R1 reset again clears enables
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    cyc(24'h0C8000, 1'b0, 1'b0); chk("R1 after reset", 2'b01);
    cyc(24'h0FFFFF, 1'b1, 1'b1); chk("R1 after reset", 2'b01);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule